// File: doc/BRIEF.md
# Register Renamer with Whole-Instruction Rollback

This block keeps the mapping from the architectural register names of a microcoded CPU to a larger pool of physical registers. Each write that an instruction makes to a register name gets a physical register that nothing currently holds. The name is pointed at the new register, so the value it held before the instruction stays untouched. A checkpoint copy of the mapping is taken at every instruction boundary. When an exception hits, a single abort cycle puts the whole mapping back to that checkpoint and returns every register allocated since. No microcode has to undo autoincrement or autodecrement side effects.

Besides the 16 architectural names, the block renames 8 temporary names (16 to 23) that micro-ops use inside one instruction. These are dropped at every instruction boundary. A fast interrupt mode hides the lowest `NINT` architectural names behind unmapped entries, so interrupt code can write them without saving them first. On interrupt exit, the mapping from before the interrupt comes back.

Read ports and the allocate port are combinational on the registered map. Commit, abort, interrupt entry and interrupt exit take effect at the next clock edge.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural name i (0 to 15) reads as valid and maps to physical register i. Temporary names 16 to 23 read as invalid (`rd_valid`=0). Physical registers 16 to 47 are free.
- R2: A granted allocate returns, on `al_tag` in the same cycle, the lowest-numbered free physical register. From the next cycle on, the name maps to that register and the register is no longer free. A register that is still mapped or checkpointed is never handed out.
- R3: A read of a name in the same cycle as a granted allocate to that name returns the mapping from before the allocate.
- R4: `abort` restores the checkpoint mapping in one cycle. Every physical register allocated since the checkpoint becomes free again.
- R5: `commit` makes the current mapping the new checkpoint. It frees every physical register that no architectural name maps to, apart from registers held for a pending interrupt return.
- R6: Temporary names are unmapped after every commit, abort, interrupt entry and interrupt exit.
- R7: An allocate request with no free register raises `al_stall`, is not granted and changes no mapping.
- R8: `int_enter` outside interrupt mode leaves names 0 to NINT-1 unmapped and keeps the other architectural names at their checkpoint mappings. It drops any uncommitted allocations, keeps the registers those names held out of the free pool, and sets `in_int`.
- R9: `int_exit` in interrupt mode restores the architectural mapping from before the interrupt and clears `in_int`. It frees every physical register that mapping does not use.
- R10: Priority is abort, then commit, then exit, then entry. An allocate is not granted in a cycle where any of the four controls is asserted.
- R11: A name of 24 or above reads as invalid, and an allocate to it is not granted.
- R12: `int_enter` while in interrupt mode and `int_exit` outside it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_name | input | NRD x 5 | Names looked up by the read ports |
| rd_tag | output | NRD x 6 | Physical register for each read port |
| rd_valid | output | NRD | Name is currently mapped |
| al_req | input | 1 | Request a fresh register for `al_name` |
| al_name | input | 5 | Name being written |
| al_grant | output | 1 | Allocate accepted this cycle |
| al_tag | output | 6 | Physical register given on grant |
| al_stall | output | 1 | Allocate refused because the pool is empty |
| commit | input | 1 | Instruction finished |
| abort | input | 1 | Instruction faulted; roll back |
| int_enter | input | 1 | Enter fast interrupt mode |
| int_exit | input | 1 | Leave fast interrupt mode |
| in_int | output | 1 | Interrupt mode active |

## Verification
The hardest state to reach is an empty free pool inside interrupt mode, with held pre-interrupt registers, uncommitted allocations and temporaries all present at once. That is where a wrong free-pool recompute at commit or exit would show. Directed sequences first exhaust the pool from reset and check the stall. They then enter interrupt mode, write the hidden names, commit and leave. After that, a long pseudo-random run mixes allocates with rare commits, aborts and interrupt transitions. The bench keeps its own mapping model and compares every read port, grant, stall and granted tag on each cycle.

// File: rtl/ren_pkg.sv
package ren_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ABORT,
        OP_COMMIT,
        OP_LEAVE,
        OP_ENTER,
        OP_ALLOC
    } ren_op_e;
endpackage

// File: rtl/ren_pick.sv
module ren_pick #(
    parameter int N = 48,
    parameter int W = 6
) (
    input  logic [N-1:0] avail,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |avail;
        idx   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (avail[p]) idx = W'(p);
        end
    end
endmodule

// File: rtl/ren_occupancy.sv
module ren_occupancy #(
    parameter int NENT  = 16,
    parameter int NPHYS = 48,
    parameter int TW    = 6
) (
    input  logic [NENT-1:0][TW:0] ents,
    output logic [NPHYS-1:0]      used
);
    always_comb begin
        used = '0;
        for (int e = 0; e < NENT; e++) begin
            for (int p = 0; p < NPHYS; p++) begin
                if (ents[e][TW] && ents[e][TW-1:0] == TW'(p)) used[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
    import ren_pkg::*;
#(
    parameter int NARCH = 16,
    parameter int NTMP  = 8,
    parameter int NPHYS = 48,
    parameter int NINT  = 6,
    parameter int NRD   = 2,
    parameter int TW    = $clog2(NPHYS),
    parameter int NW    = $clog2(NARCH + NTMP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][NW-1:0]  rd_name,
    output logic [NRD-1:0][TW-1:0]  rd_tag,
    output logic [NRD-1:0]          rd_valid,
    input  logic                    al_req,
    input  logic [NW-1:0]           al_name,
    output logic                    al_grant,
    output logic [TW-1:0]           al_tag,
    output logic                    al_stall,
    input  logic                    commit,
    input  logic                    abort,
    input  logic                    int_enter,
    input  logic                    int_exit,
    output logic                    in_int
);
    localparam int NNAME = NARCH + NTMP;

    typedef logic [TW:0] ent_t;   // [TW] valid, [TW-1:0] physical tag

    typedef struct packed {
        ent_t [NNAME-1:0] map;
        ent_t [NNAME-1:0] ckpt;
        ent_t [NARCH-1:0] isave;
        logic [NPHYS-1:0] free;
        logic             in_int;
    } st_t;

    st_t s_q, s_d;
    ren_op_e op;

    logic             pick_found;
    logic [TW-1:0]    pick_idx;
    logic [NPHYS-1:0] arch_used, ckpt_used, isave_used, held;
    logic             ctrl, name_ok;

    function automatic st_t reset_state();
        st_t r;
        r = '0;
        for (int i = 0; i < NARCH; i++) begin
            r.map[i]  = {1'b1, TW'(i)};
            r.ckpt[i] = {1'b1, TW'(i)};
        end
        for (int p = NARCH; p < NPHYS; p++) r.free[p] = 1'b1;
        return r;
    endfunction

    function automatic ent_t [NNAME-1:0] widen(input ent_t [NARCH-1:0] a);
        ent_t [NNAME-1:0] w;
        w = '0;
        for (int i = 0; i < NARCH; i++) w[i] = a[i];
        return w;
    endfunction

    ren_pick #(.N(NPHYS), .W(TW)) u_pick (
        .avail(s_q.free), .found(pick_found), .idx(pick_idx)
    );
    ren_occupancy #(.NENT(NARCH), .NPHYS(NPHYS), .TW(TW)) u_occ_arch (
        .ents(s_q.map[NARCH-1:0]), .used(arch_used)
    );
    ren_occupancy #(.NENT(NNAME), .NPHYS(NPHYS), .TW(TW)) u_occ_ckpt (
        .ents(s_q.ckpt), .used(ckpt_used)
    );
    ren_occupancy #(.NENT(NARCH), .NPHYS(NPHYS), .TW(TW)) u_occ_isave (
        .ents(s_q.isave), .used(isave_used)
    );

    always_comb begin
        ctrl    = commit | abort | int_enter | int_exit;
        name_ok = (32'(al_name) < NNAME);
        held    = s_q.in_int ? isave_used : '0;
        if (abort)                          op = OP_ABORT;
        else if (commit)                    op = OP_COMMIT;
        else if (int_exit && s_q.in_int)    op = OP_LEAVE;
        else if (int_enter && !s_q.in_int)  op = OP_ENTER;
        else if (!ctrl && al_req && pick_found && name_ok) op = OP_ALLOC;
        else                                op = OP_IDLE;

        al_grant = (op == OP_ALLOC);
        al_stall = al_req && !ctrl && !pick_found;
        al_tag   = pick_idx;
        in_int   = s_q.in_int;
        for (int r = 0; r < NRD; r++) begin
            if (32'(rd_name[r]) < NNAME) begin
                rd_valid[r] = s_q.map[rd_name[r]][TW];
                rd_tag[r]   = s_q.map[rd_name[r]][TW-1:0];
            end else begin
                rd_valid[r] = 1'b0;
                rd_tag[r]   = '0;
            end
        end

        s_d = s_q;
        case (op)
            OP_ALLOC: begin
                s_d.map[al_name]  = {1'b1, pick_idx};
                s_d.free[pick_idx] = 1'b0;
            end
            OP_ABORT: begin
                s_d.map  = s_q.ckpt;
                s_d.free = ~(ckpt_used | held);
            end
            OP_COMMIT: begin
                s_d.map  = widen(s_q.map[NARCH-1:0]);
                s_d.ckpt = widen(s_q.map[NARCH-1:0]);
                s_d.free = ~(arch_used | held);
            end
            OP_LEAVE: begin
                s_d.map    = widen(s_q.isave);
                s_d.ckpt   = widen(s_q.isave);
                s_d.free   = ~isave_used;
                s_d.in_int = 1'b0;
            end
            OP_ENTER: begin
                s_d.isave = s_q.ckpt[NARCH-1:0];
                s_d.map   = s_q.ckpt;
                for (int i = 0; i < NINT; i++) s_d.map[i][TW] = 1'b0;
                s_d.ckpt   = s_d.map;
                s_d.free   = ~ckpt_used;
                s_d.in_int = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    // R2: a granted register is held by no live, checkpointed or saved mapping
    p_fresh_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        al_grant |-> !arch_used[al_tag] && !ckpt_used[al_tag] && !held[al_tag]);

    // R2: without a control, the free pool never gains a register
    p_no_regain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ALLOC || op == OP_IDLE) |=> (s_q.free & ~$past(s_q.free)) == '0);

    // R4: abort puts the checkpoint back
    p_rollback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> s_q.map == $past(s_q.ckpt));

    // R5: commit aligns checkpoint and map
    p_commit_ckpt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> s_q.ckpt == s_q.map);

    // R7: a stalled request leaves the mapping alone
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        al_stall |=> s_q.map == $past(s_q.map));

    // R9: exit brings back the saved architectural mapping
    p_leave_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LEAVE) |=> s_q.map[NARCH-1:0] == $past(s_q.isave) && !in_int);
endmodule

// File: tb/sim_reg_renamer.sv
module sim_reg_renamer;
    localparam int NARCH = 16, NTMP = 8, NPHYS = 48, NINT = 6;
    localparam int NNAME = NARCH + NTMP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0][4:0] rd_name;
    logic [1:0][5:0] rd_tag;
    logic [1:0]      rd_valid;
    logic al_req, al_grant, al_stall, commit, abort, int_enter, int_exit, in_int;
    logic [4:0] al_name;
    logic [5:0] al_tag;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    reg_renamer u0 (
        .clk(clk), .rst_n(rst_n), .rd_name(rd_name), .rd_tag(rd_tag),
        .rd_valid(rd_valid), .al_req(al_req), .al_name(al_name),
        .al_grant(al_grant), .al_tag(al_tag), .al_stall(al_stall),
        .commit(commit), .abort(abort), .int_enter(int_enter),
        .int_exit(int_exit), .in_int(in_int)
    );

    // model state
    logic       mv [NNAME], cv [NNAME], sv [NARCH];
    int         mt [NNAME], ct [NNAME], st [NARCH];
    logic       fr [NPHYS];
    logic       mint;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NNAME; i++) begin
            mv[i] = (i < NARCH); mt[i] = i; cv[i] = mv[i]; ct[i] = i;
        end
        for (int i = 0; i < NARCH; i++) begin sv[i] = 1'b0; st[i] = 0; end
        for (int p = 0; p < NPHYS; p++) fr[p] = (p >= NARCH);
        mint = 1'b0;
    endfunction

    function automatic void refree(input logic usev [NNAME], input int uset [NNAME],
                                   input int nent, input logic addsave);
        for (int p = 0; p < NPHYS; p++) fr[p] = 1'b1;
        for (int i = 0; i < nent; i++) if (usev[i]) fr[uset[i]] = 1'b0;
        if (addsave) for (int i = 0; i < NARCH; i++) if (sv[i]) fr[st[i]] = 1'b0;
    endfunction

    // one cycle: drive, compare combinational outputs, update model, clock
    task automatic step(input string req, input logic rq, input int nm,
                        input logic cm, input logic ab, input logic en, input logic ex,
                        input int r0, input int r1);
        int lo; logic fnd, ctl, grant; int rn [2];
        logic tv [NNAME]; int tt [NNAME];
        @(negedge clk);
        al_req = rq; al_name = 5'(nm); commit = cm; abort = ab;
        int_enter = en; int_exit = ex;
        rd_name[0] = 5'(r0); rd_name[1] = 5'(r1);
        rn[0] = r0; rn[1] = r1;
        #1;
        lo = 0; fnd = 1'b0;
        for (int p = NPHYS - 1; p >= 0; p--) if (fr[p]) begin lo = p; fnd = 1'b1; end
        ctl = cm | ab | en | ex;
        grant = rq && !ctl && fnd && (nm < NNAME);
        for (int r = 0; r < 2; r++) begin
            if (rn[r] < NNAME) begin
                chk({req, " rd_valid"}, int'(rd_valid[r]), int'(mv[rn[r]]));
                if (mv[rn[r]]) chk({req, " rd_tag"}, int'(rd_tag[r]), mt[rn[r]]);
            end else chk({req, " R11 rd_valid"}, int'(rd_valid[r]), 0);
        end
        chk({req, " al_grant"}, int'(al_grant), int'(grant));
        chk({req, " al_stall"}, int'(al_stall), int'(rq && !ctl && !fnd));
        chk({req, " in_int"}, int'(in_int), int'(mint));
        if (grant) chk({req, " al_tag"}, int'(al_tag), lo);
        // model update
        if (ab) begin
            mv = cv; mt = ct; refree(cv, ct, NNAME, mint);
        end else if (cm) begin
            for (int i = NARCH; i < NNAME; i++) mv[i] = 1'b0;
            cv = mv; ct = mt; refree(mv, mt, NARCH, mint);
        end else if (ex && mint) begin
            for (int i = 0; i < NNAME; i++) begin
                tv[i] = (i < NARCH) ? sv[i] : 1'b0; tt[i] = (i < NARCH) ? st[i] : 0;
            end
            mv = tv; mt = tt; cv = tv; ct = tt; refree(tv, tt, NARCH, 1'b0);
            mint = 1'b0;
        end else if (en && !mint) begin
            for (int i = 0; i < NARCH; i++) begin sv[i] = cv[i]; st[i] = ct[i]; end
            refree(cv, ct, NNAME, 1'b0);
            mv = cv; mt = ct;
            for (int i = 0; i < NINT; i++) mv[i] = 1'b0;
            cv = mv; ct = mt; mint = 1'b1;
        end else if (grant) begin
            mv[nm] = 1'b1; mt[nm] = lo; fr[lo] = 1'b0;
        end
        @(posedge clk);
    endtask

    task automatic idle_read(input string req, input int a, input int b);
        step(req, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, a, b);
    endtask

    task automatic alloc(input string req, input int nm, input int a, input int b);
        step(req, 1'b1, nm, 1'b0, 1'b0, 1'b0, 1'b0, a, b);
    endtask

    task automatic ctl_step(input string req, input logic cm, input logic ab,
                            input logic en, input logic ex);
        step(req, 1'b1, 3, cm, ab, en, ex, 0, 3);
    endtask

    initial begin : watchdog
        while (cycles < 200000) begin @(posedge clk); cycles++; end
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 200000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] lf;
        al_req = 0; al_name = 0; commit = 0; abort = 0; int_enter = 0; int_exit = 0;
        rd_name = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset map, every name swept, R11 out-of-range names
        for (int n = 0; n < 32; n += 2) idle_read("R1", n, n + 1);
        // R2/R3: allocate writes r1 while reading r1 the same cycle
        alloc("R3", 1, 1, 2);
        idle_read("R2", 1, 2);
        alloc("R2", 1, 1, 0);          // second write to same name
        alloc("R2 tmp", 18, 18, 1);     // temporary name
        // R4: abort restores and frees
        step("R4", 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 18);
        alloc("R4", 5, 5, 1);           // lowest free again 16
        // R5/R6: commit frees displaced reg 5; temps dropped
        alloc("R6", 20, 20, 5);
        step("R5", 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 5, 20);
        alloc("R5", 7, 5, 20);          // reuses physical 5
        // R10: abort with commit together, alloc blocked
        step("R10", 1'b1, 9, 1'b1, 1'b1, 1'b0, 1'b0, 7, 9);
        step("R10", 1'b1, 9, 1'b0, 1'b0, 1'b0, 1'b1, 7, 9);
        // R11: allocate to invalid name
        alloc("R11", 27, 27, 7);
        // R7: exhaust pool then stall
        for (int k = 0; k < 40; k++) alloc("R7", k % NNAME, k % NNAME, (k + 3) % NNAME);
        alloc("R7", 4, 4, 5);
        idle_read("R7", 4, 5);
        step("R7", 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4, 20);
        // R12: exit outside interrupt ignored
        ctl_step("R12", 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: enter, hidden names invalid
        ctl_step("R8", 1'b0, 1'b0, 1'b1, 1'b0);
        for (int n = 0; n < NARCH; n += 2) idle_read("R8", n, n + 1);
        ctl_step("R12", 1'b0, 1'b0, 1'b1, 1'b0);
        alloc("R8", 0, 0, 6);
        alloc("R8", 9, 9, 0);
        step("R8", 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 9);
        alloc("R8", 2, 2, 9);
        // R9: exit restores
        ctl_step("R9", 1'b0, 1'b0, 1'b0, 1'b1);
        for (int n = 0; n < NARCH; n += 2) idle_read("R9", n, n + 1);

        // sweep: pseudo-random mix against the model (R2 R4 R5 R7 R8 R9 R10)
        lf = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R2 sweep", lf[0], int'(lf[5:1]) % 26,
                 lf[8:6] == 3'd0, lf[11:9] == 3'd7 && lf[1],
                 lf[15:12] == 4'd3, lf[15:12] == 4'd9,
                 int'(lf[10:6]), int'(lf[15:11]));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule